// File: doc/BRIEF.md
# Remote Queue Address Translator

This block sits on the receive path of a network interface. Each incoming short message names a destination queue by a small queue number instead of carrying a memory address. The block keeps a table of circular-queue descriptors, one per queue. It turns each message into the host physical address where that message's data must be written.

A descriptor holds a 64-bit base address, a head offset and a wrap offset. For each enqueue the block reads the descriptor and emits base plus head. It then moves the head forward by the message length, rounded up to whole 8-byte words. When the moved head reaches or passes the wrap offset, the head folds back to zero, so the next address is the base again.

Enqueues are taken one per cycle. The head written back by one enqueue is the head seen by the very next one, so messages from different senders to the same queue each get a slot of their own. Software programs and inspects descriptors through a 32-bit register port. A register write always wins over a lookup in the same cycle.

Top module: `rqx_top`

## Requirements
- R1: After reset every descriptor field reads as zero, `out_valid` is low, `err_count` is zero and `enq_ready` is high.
- R2: `cfg_addr` is {queue number, word select}. Word 0 is base[31:0], word 1 is base[63:32], word 2 is the head offset and word 3 is the wrap offset. A read raised in one cycle returns `cfg_rdata` with `cfg_rvalid` high in the following cycle.
- R3: The emitted address is the 64-bit sum of the queue's base and its current head offset.
- R4: After an accepted enqueue the head offset grows by the message length in bytes, rounded up to the next multiple of 8.
- R5: If the grown head is greater than or equal to the wrap offset, the head becomes zero instead, and the next address for that queue equals its base.
- R6: One enqueue is accepted per cycle. An enqueue accepted in the cycle right after another one to the same queue sees the head that the first one left.
- R7: The output is a valid/ready stream. While `out_valid` is high and `out_ready` is low, `out_addr` and `out_qid` hold steady and `enq_ready` is low. An accepted enqueue shows on the output in the next cycle.
- R8: In a cycle with `cfg_wr` high, `enq_ready` is low and the write is applied. A lookup held back by that write uses the newly written value.
- R9: An enqueue to a queue whose wrap offset is zero is accepted but produces no output. It leaves that queue's head unchanged and increments `err_count` by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Enqueue request present |
| enq_ready | output | 1 | Enqueue request taken this cycle when valid |
| enq_qid | input | QID_W | Target queue number |
| enq_len | input | LEN_W | Message length in bytes |
| out_valid | output | 1 | Translated address present |
| out_ready | input | 1 | Downstream accepts the address |
| out_addr | output | 64 | Host physical write address |
| out_qid | output | QID_W | Queue that produced the address |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | QID_W+2 | Queue number and word select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |
| cfg_rvalid | output | 1 | Read data valid |
| err_count | output | ERR_W | Count of dropped enqueues |

## Verification
The assertions assume that software writes only head and wrap offsets that are multiples of 8, and that it keeps each head below its nonzero wrap offset. Without that, the head could not be shown to stay inside the ring. The stimulus programs descriptors only with such values and changes a head only to a value under the wrap. The bench holds enqueues back only through `enq_ready`, so the assertions about held output and blocked writes see the handshake used as intended.

// File: rtl/rqx_pkg.sv
package rqx_pkg;
  localparam int PA_W  = 64;
  localparam int OFF_W = 32;

  // Descriptor layout: wrap [127:96], head [95:64], base [63:0]
  typedef struct packed {
    logic [OFF_W-1:0] wrap;
    logic [OFF_W-1:0] head;
    logic [PA_W-1:0]  base;
  } rqx_desc_t;
endpackage

// File: rtl/rqx_table.sv
module rqx_table
  import rqx_pkg::*;
#(
  parameter int NUM_Q = 256,
  parameter int QID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_rd,
  input  logic [QID_W-1:0] cfg_qid,
  input  logic [1:0]       cfg_word,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  output logic             cfg_rvalid,
  input  logic [QID_W-1:0] lk_qid,
  output rqx_desc_t        lk_desc,
  input  logic             hd_we,
  input  logic [QID_W-1:0] hd_qid,
  input  logic [OFF_W-1:0] hd_val
);
  rqx_desc_t slots [NUM_Q];
  rqx_desc_t rd_desc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_Q; i++) slots[i] <= '0;
    end else if (cfg_wr) begin
      case (cfg_word)
        2'd0: slots[cfg_qid].base[31:0]  <= cfg_wdata;
        2'd1: slots[cfg_qid].base[63:32] <= cfg_wdata;
        2'd2: slots[cfg_qid].head        <= cfg_wdata;
        default: slots[cfg_qid].wrap     <= cfg_wdata;
      endcase
    end else if (hd_we) begin
      slots[hd_qid].head <= hd_val;
    end
  end

  assign lk_desc = slots[lk_qid];
  assign rd_desc = slots[cfg_qid];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_rvalid <= 1'b0;
      cfg_rdata  <= '0;
    end else begin
      cfg_rvalid <= cfg_rd;
      if (cfg_rd) begin
        case (cfg_word)
          2'd0: cfg_rdata <= rd_desc.base[31:0];
          2'd1: cfg_rdata <= rd_desc.base[63:32];
          2'd2: cfg_rdata <= rd_desc.head;
          default: cfg_rdata <= rd_desc.wrap;
        endcase
      end
    end
  end

  // R8: a software write and a head update never share a cycle
  a_r8_no_write_clash: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && hd_we));
endmodule

// File: rtl/rqx_advance.sv
module rqx_advance
  import rqx_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  rqx_desc_t        desc,
  input  logic [LEN_W-1:0] len,
  output logic [PA_W-1:0]  addr,
  output logic [OFF_W-1:0] next_head,
  output logic             drop
);
  localparam int SUM_W = OFF_W + 1;

  logic [SUM_W-1:0] len_up;
  logic [SUM_W-1:0] sum;

  always_comb begin
    len_up    = (SUM_W'(len) + SUM_W'(7)) & ~SUM_W'(7);
    sum       = SUM_W'(desc.head) + len_up;
    addr      = desc.base + PA_W'(desc.head);
    drop      = (desc.wrap == '0);
    next_head = (sum >= SUM_W'(desc.wrap)) ? '0 : sum[OFF_W-1:0];
  end
endmodule

// File: rtl/rqx_outreg.sv
module rqx_outreg
  import rqx_pkg::*;
#(
  parameter int QID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PA_W-1:0]  in_addr,
  input  logic [QID_W-1:0] in_qid,
  output logic             free,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PA_W-1:0]  out_addr,
  output logic [QID_W-1:0] out_qid
);
  assign free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_qid   <= '0;
    end else if (free) begin
      out_valid <= load;
      if (load) begin
        out_addr <= in_addr;
        out_qid  <= in_qid;
      end
    end
  end

  // R7: a stalled address stays put
  a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_qid)));
endmodule

// File: rtl/rqx_top.sv
module rqx_top
  import rqx_pkg::*;
#(
  parameter int NUM_Q = 256,
  parameter int QID_W = 8,
  parameter int LEN_W = 12,
  parameter int ERR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enq_valid,
  output logic               enq_ready,
  input  logic [QID_W-1:0]   enq_qid,
  input  logic [LEN_W-1:0]   enq_len,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [63:0]        out_addr,
  output logic [QID_W-1:0]   out_qid,
  input  logic               cfg_wr,
  input  logic               cfg_rd,
  input  logic [QID_W+1:0]   cfg_addr,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  output logic               cfg_rvalid,
  output logic [ERR_W-1:0]   err_count
);
  rqx_desc_t        desc;
  logic [PA_W-1:0]  addr;
  logic [OFF_W-1:0] next_head;
  logic             drop;
  logic             free;
  logic             take;

  assign enq_ready = free && !cfg_wr;
  assign take      = enq_valid && enq_ready;

  rqx_table #(.NUM_Q(NUM_Q), .QID_W(QID_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_qid(cfg_addr[QID_W+1:2]), .cfg_word(cfg_addr[1:0]),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
    .lk_qid(enq_qid), .lk_desc(desc),
    .hd_we(take && !drop), .hd_qid(enq_qid), .hd_val(next_head)
  );

  rqx_advance #(.LEN_W(LEN_W)) u_adv (
    .desc(desc), .len(enq_len),
    .addr(addr), .next_head(next_head), .drop(drop)
  );

  rqx_outreg #(.QID_W(QID_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .load(take && !drop), .in_addr(addr), .in_qid(enq_qid),
    .free(free), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_qid(out_qid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)            err_count <= '0;
    else if (take && drop) err_count <= err_count + 1'b1;
  end

  // R9: a dropped enqueue produces nothing on the output
  a_r9_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (take && drop) |=> !out_valid);

  // R9: each drop adds exactly one to the error count
  a_r9_err_step: assert property (@(posedge clk) disable iff (!rst_n)
    (take && drop) |=> (err_count == $past(err_count) + 1'b1));

  // R5: a head written back always lies inside the ring
  a_r5_head_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !drop) |-> (next_head < desc.wrap));
endmodule

// File: tb/rqx_top_bench.sv
module rqx_top_bench;
  localparam int QID_W = 8;
  localparam int LEN_W = 12;
  localparam logic [63:0] B3 = 64'h0000_0001_2345_0000;
  localparam logic [63:0] B7 = 64'hFFFF_0000_0000_0100;
  localparam int NV = 9;
  // {qid, len, expected head offset before this enqueue}
  localparam logic [51:0] VEC [NV] = '{
    {8'd3, 12'd8,  32'd0},
    {8'd3, 12'd13, 32'd8},
    {8'd7, 12'd1,  32'd0},
    {8'd3, 12'd40, 32'd24},
    {8'd3, 12'd8,  32'd0},
    {8'd7, 12'd16, 32'd8},
    {8'd7, 12'd8,  32'd0},
    {8'd3, 12'd64, 32'd8},
    {8'd3, 12'd7,  32'd0}
  };

  logic clk = 0, rst_n = 0;
  logic enq_valid = 0, out_ready = 1, cfg_wr = 0, cfg_rd = 0;
  logic [QID_W-1:0] enq_qid = '0;
  logic [LEN_W-1:0] enq_len = '0;
  logic [QID_W+1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic enq_ready, out_valid, cfg_rvalid;
  logic [63:0] out_addr;
  logic [QID_W-1:0] out_qid;
  logic [31:0] cfg_rdata;
  logic [15:0] err_count;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rqx_top u_rqx_top (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_ready(enq_ready),
    .enq_qid(enq_qid), .enq_len(enq_len), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr), .out_qid(out_qid),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
    .err_count(err_count)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] q, input logic [1:0] w, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_addr = {q, w}; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic cfg_read_chk(input string req, input logic [7:0] q, input logic [1:0] w,
                              input logic [31:0] exp);
    @(negedge clk);
    cfg_rd = 1; cfg_addr = {q, w};
    @(negedge clk);
    cfg_rd = 0;
    chk(req, {31'd0, cfg_rvalid, cfg_rdata}, {31'd0, 1'b1, exp});
  endtask

  function automatic logic [63:0] base_of(input logic [7:0] q);
    return (q == 8'd3) ? B3 : B7;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 out_valid", out_valid, 0);
    chk("R1 err_count", err_count, 0);
    chk("R1 enq_ready", enq_ready, 1);
    cfg_read_chk("R1 wrap zero", 8'd5, 2'd3, 32'd0);

    // R2: program queues 3 and 7
    cfg_write(8'd3, 2'd0, B3[31:0]);
    cfg_write(8'd3, 2'd1, B3[63:32]);
    cfg_write(8'd3, 2'd3, 32'd64);
    cfg_write(8'd7, 2'd0, B7[31:0]);
    cfg_write(8'd7, 2'd1, B7[63:32]);
    cfg_write(8'd7, 2'd3, 32'd24);
    cfg_read_chk("R2 base hi", 8'd7, 2'd1, 32'hFFFF_0000);
    cfg_read_chk("R2 base lo", 8'd3, 2'd0, 32'h2345_0000);

    // R3 R4 R5 R6: back-to-back vector walk
    for (int i = 0; i <= NV; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk("R6 out_valid", out_valid, 1);
        chk("R3/R4/R5 addr", out_addr,
            base_of(VEC[i-1][51:44]) + {32'd0, VEC[i-1][31:0]});
      end
      if (i < NV) begin
        enq_valid = 1; enq_qid = VEC[i][51:44]; enq_len = VEC[i][43:32];
      end else enq_valid = 0;
    end
    cfg_read_chk("R4 head q3", 8'd3, 2'd2, 32'd8);

    // R7: back-pressure
    @(negedge clk);
    out_ready = 0; enq_valid = 1; enq_qid = 8'd3; enq_len = 12'd8;
    @(negedge clk);
    chk("R7 first addr", out_addr, B3 + 64'd8);
    chk("R7 ready low", enq_ready, 0);
    repeat (2) @(negedge clk);
    chk("R7 addr held", out_addr, B3 + 64'd8);
    chk("R7 valid held", out_valid, 1);
    out_ready = 1;
    @(negedge clk);
    enq_valid = 0;
    chk("R7 second addr", out_addr, B3 + 64'd16);

    // R8: write beats lookup, stalled lookup sees new head
    @(negedge clk);
    cfg_wr = 1; cfg_addr = {8'd3, 2'd2}; cfg_wdata = 32'd40;
    enq_valid = 1; enq_qid = 8'd3; enq_len = 12'd8;
    #1 chk("R8 ready low", enq_ready, 0);
    @(negedge clk);
    cfg_wr = 0;
    @(negedge clk);
    enq_valid = 0;
    chk("R8 new head used", out_addr, B3 + 64'd40);
    cfg_read_chk("R8 head after", 8'd3, 2'd2, 32'd48);

    // R9: wrap zero drop
    @(negedge clk);
    enq_valid = 1; enq_qid = 8'd9; enq_len = 12'd8;
    @(negedge clk);
    enq_valid = 0;
    chk("R9 no output", out_valid, 0);
    chk("R9 err_count", err_count, 1);
    cfg_read_chk("R9 head kept", 8'd9, 2'd2, 32'd0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule